// File: doc/BRIEF.md
# Bank Chip-Select Dispatcher

This block sits between an internal request source and a group of external-bus controller machines. Each incoming request carries a 32-bit address. That address is compared against four programmable bank windows. The lowest-numbered valid bank that matches has its active-low chip select driven. The controller machine bound to that bank gets a one-cycle start pulse and keeps ownership of the external bus until it returns its done strobe. Five machines can be bound to a bank: a general-purpose timing machine (code 0), a flash machine (code 1) and three user-programmable machines (codes 2, 3 and 4). Any number of banks may share one machine.

A refresh request breaks the one-chip-select rule on purpose. During refresh, every valid bank that is bound to a user-programmable machine and has refresh enabled drives its chip select at the same time, until `refresh_done` arrives. If a refresh request arrives during a transfer, it waits for the transfer to finish. New requests are refused while a refresh is pending or running.

The controller has three states. In IDLE it accepts requests. XFER means a bank is owned by its machine. REFR is the refresh burst. The transitions are as follows:
- IDLE→REFR when a refresh is requested or pending.
- IDLE→XFER when a request hits a bank.
- IDLE→IDLE on a miss, which raises an error pulse.
- XFER→IDLE when the owner's done arrives with no refresh waiting.
- XFER→REFR when the owner's done arrives with a refresh waiting.
- REFR→IDLE when `refresh_done` arrives.

Top module: `csel_dispatch`

## Requirements
- R1: While reset is asserted and right after it, all `cs_n` bits are 1, `owner_valid` and `refresh_active` are 0 and `req_ready` is 1.
- R2: A bank matches when its ctrl valid bit (bit 0) is set and (addr AND mask) equals (base AND mask). On an accepted matching request, that bank's `cs_n` bit is 0 from the cycle after acceptance.
- R3: When several valid banks match, the lowest-numbered one is selected.
- R4: A bank whose valid bit is clear never matches, even if its window covers the address.
- R5: A request matching no bank gives exactly one cycle of `miss_err`, in the cycle after acceptance. It drives no chip select and no start pulse.
- R6: On a hit, `mach_start` carries a single one-cycle pulse on bit index equal to the bank's machine code, which is ctrl bits [3:1]. `owner` shows that code and `owner_valid` is 1.
- R7: Ownership and the chip select are held until `mach_done[owner]` is 1. Done bits of other machines are ignored, and `req_ready` is 0 meanwhile.
- R8: Outside refresh, at most one `cs_n` bit is 0.
- R9: During refresh, `refresh_active` is 1. `cs_n` is 0 for exactly those banks that are valid, have machine code 2 to 4 and have refresh enable (ctrl bit 4) set. The refresh lasts until `refresh_done` is sampled high.
- R10: A refresh request made during a transfer is held pending. Refresh begins the cycle after the owner's done. No request is accepted (`req_ready` is 0) while a refresh is pending or active.
- R11: Config writes select the field with `cfg_sel`: 0 is base, 1 is mask, 2 is ctrl. A ctrl machine code of 5 to 7 makes the bank never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_bank | input | 2 | Bank being written |
| cfg_sel | input | 2 | Field: 0 base, 1 mask, 2 ctrl |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Transaction request |
| req_addr | input | 32 | Transaction address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| refresh_req | input | 1 | Refresh request strobe |
| refresh_done | input | 1 | Refresh burst finished |
| mach_done | input | 5 | Per-machine done strobes |
| mach_start | output | 5 | Per-machine one-cycle start pulses |
| owner | output | 3 | Code of the owning machine |
| owner_valid | output | 1 | A transfer owns the bus |
| cs_n | output | 4 | Active-low chip selects |
| refresh_active | output | 1 | Refresh burst in progress |
| miss_err | output | 1 | One-cycle no-match error pulse |

## Verification
The embedded properties check the following on every cycle:
- The one-chip-select rule outside refresh.
- That a miss never coincides with a chip select or start.
- That start pulses are single, one-hot and last one cycle.
- That ownership stays stable until its own done.
- That no request is accepted during refresh.

The bench scenarios are needed for the rest:
- Address matching and masking, the lowest-bank priority and the invalid-bank and bad-code cases.
- The exact set of banks lit during refresh.
- That a deferred refresh starts in the cycle after a transfer ends.

// File: rtl/csel_pkg.sv
package csel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_REFR = 2'd2
    } st_t;

    typedef logic [2:0] mach_t;

    localparam int    NMACH      = 5;
    localparam mach_t M_GENERAL  = 3'd0;
    localparam mach_t M_FLASH    = 3'd1;
    localparam mach_t M_USER_LO  = 3'd2;
    localparam mach_t M_USER_HI  = 3'd4;

    typedef struct packed {
        logic  ref_en;
        mach_t mach;
        logic  valid;
    } bank_ctl_t;
endpackage

// File: rtl/csel_bank_regs.sv
module csel_bank_regs
    import csel_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 32,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [BW-1:0]             bank,
    input  logic [1:0]                sel,
    input  logic [AW-1:0]             wdata,
    output logic [NB-1:0][AW-1:0]     base_o,
    output logic [NB-1:0][AW-1:0]     mask_o,
    output bank_ctl_t [NB-1:0]        ctl_o
);
    localparam int CW = $bits(bank_ctl_t);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit_w;
        assign hit_w = we && (bank == BW'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[b] <= '0;
                mask_o[b] <= '0;
                ctl_o[b]  <= '0;
            end else if (hit_w) begin
                unique case (sel)
                    2'd0:    base_o[b] <= wdata;
                    2'd1:    mask_o[b] <= wdata;
                    2'd2:    ctl_o[b]  <= bank_ctl_t'(wdata[CW-1:0]);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 32,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [AW-1:0]             addr,
    input  logic [NB-1:0][AW-1:0]     base,
    input  logic [NB-1:0][AW-1:0]     mask,
    input  bank_ctl_t [NB-1:0]        ctl,
    output logic                      hit,
    output logic [BW-1:0]             hit_bank,
    output mach_t                     hit_mach,
    output logic [NB-1:0]             ref_set
);
    logic [NB-1:0] m_vec;

    for (genvar b = 0; b < NB; b++) begin : g_cmp
        logic code_ok, is_user;
        assign code_ok    = ctl[b].mach <= M_USER_HI;
        assign is_user    = (ctl[b].mach >= M_USER_LO) && code_ok;
        assign m_vec[b]   = ctl[b].valid && code_ok &&
                            ((addr & mask[b]) == (base[b] & mask[b]));
        assign ref_set[b] = ctl[b].valid && is_user && ctl[b].ref_en;
    end

    always_comb begin
        hit      = |m_vec;
        hit_bank = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (m_vec[i]) hit_bank = BW'(i);
        end
        hit_mach = ctl[hit_bank].mach;
    end
endmodule

// File: rtl/csel_dispatch.sv
module csel_dispatch
    import csel_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 32,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BW-1:0]     cfg_bank,
    input  logic [1:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              req_ready,
    input  logic              refresh_req,
    input  logic              refresh_done,
    input  logic [4:0]        mach_done,
    output logic [4:0]        mach_start,
    output logic [2:0]        owner,
    output logic              owner_valid,
    output logic [NB-1:0]     cs_n,
    output logic              refresh_active,
    output logic              miss_err
);
    logic [NB-1:0][AW-1:0] base_w, mask_w;
    bank_ctl_t [NB-1:0]    ctl_w;
    logic                  hit_w;
    logic [BW-1:0]         hit_bank_w;
    mach_t                 hit_mach_w;
    logic [NB-1:0]         ref_set_w;

    csel_bank_regs #(.NB(NB), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .bank(cfg_bank),
        .sel(cfg_sel), .wdata(cfg_wdata),
        .base_o(base_w), .mask_o(mask_w), .ctl_o(ctl_w)
    );

    csel_match #(.NB(NB), .AW(AW)) u_match (
        .addr(req_addr), .base(base_w), .mask(mask_w), .ctl(ctl_w),
        .hit(hit_w), .hit_bank(hit_bank_w), .hit_mach(hit_mach_w),
        .ref_set(ref_set_w)
    );

    st_t           state, state_n;
    logic [BW-1:0] cur_bank;
    mach_t         cur_mach;
    logic [NB-1:0] ref_mask_q;
    logic          ref_pend;
    logic [4:0]    start_q;
    logic          miss_q;
    logic [7:0]    done_ext;
    logic          done_own, ref_want, accept, enter_refr;

    assign done_ext   = {3'b000, mach_done};
    assign done_own   = done_ext[cur_mach];
    assign ref_want   = ref_pend || refresh_req;
    assign accept     = (state == ST_IDLE) && !ref_want && req_valid;
    assign enter_refr = (state_n == ST_REFR) && (state != ST_REFR);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (ref_want)             state_n = ST_REFR;
                     else if (req_valid && hit_w) state_n = ST_XFER;
            ST_XFER: if (done_own)             state_n = ref_want ? ST_REFR : ST_IDLE;
            ST_REFR: if (refresh_done)         state_n = ST_IDLE;
            default:                           state_n = ST_IDLE;
        endcase
    end

    // state and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_bank   <= '0;
            cur_mach   <= M_GENERAL;
            ref_mask_q <= '0;
            ref_pend   <= 1'b0;
            start_q    <= '0;
            miss_q     <= 1'b0;
        end else begin
            state   <= state_n;
            start_q <= (accept && hit_w) ? (5'd1 << hit_mach_w) : 5'd0;
            miss_q  <= accept && !hit_w;
            if (accept && hit_w) begin
                cur_bank <= hit_bank_w;
                cur_mach <= hit_mach_w;
            end
            if (enter_refr) begin
                ref_mask_q <= ref_set_w;
                ref_pend   <= 1'b0;
            end else if (refresh_req) begin
                ref_pend   <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        cs_n           = '1;
        owner_valid    = 1'b0;
        refresh_active = 1'b0;
        req_ready      = 1'b0;
        mach_start     = start_q;
        miss_err       = miss_q;
        owner          = cur_mach;
        unique case (state)
            ST_IDLE: req_ready = !ref_want;
            ST_XFER: begin
                cs_n[cur_bank] = 1'b0;
                owner_valid    = 1'b1;
            end
            ST_REFR: begin
                cs_n           = ~ref_mask_q;
                refresh_active = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: held in reset, nothing selected
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (cs_n == '1 && !owner_valid && !refresh_active);
        end
    end

    // R8: one chip select at most outside refresh
    a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_active |-> $onehot0(~cs_n));

    // R5: a miss drives nothing
    a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |-> (cs_n == '1 && mach_start == 5'd0));

    // R6: start pulse is one-hot and lasts one cycle
    a_r6_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mach_start));
    a_r6_start_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mach_start != 5'd0) |=> (mach_start == 5'd0));

    // R7: ownership stable until the owner's own done
    a_r7_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && !done_own) |=> (owner_valid && $stable(cs_n) && $stable(owner)));

    // R10: refresh blocks acceptance
    a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_active |-> !req_ready);
endmodule

// File: tb/csel_dispatch_test.sv
module csel_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        refresh_req = 1'b0;
    logic        refresh_done = 1'b0;
    logic [4:0]  mach_done = '0;
    logic [4:0]  mach_start;
    logic [2:0]  owner;
    logic        owner_valid;
    logic [3:0]  cs_n;
    logic        refresh_active;
    logic        miss_err;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [3:0] cs;
        logic [4:0] st;
        logic [2:0] own;
        logic       miss;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    csel_dispatch uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_ready(req_ready), .refresh_req(refresh_req),
        .refresh_done(refresh_done), .mach_done(mach_done), .mach_start(mach_start),
        .owner(owner), .owner_valid(owner_valid), .cs_n(cs_n),
        .refresh_active(refresh_active), .miss_err(miss_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] b, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = b; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: push the expected result, then issue the request
    task automatic do_req(input logic [31:0] a, input logic [3:0] cs, input logic [4:0] st,
                          input logic [2:0] own, input logic miss, input string tag);
        exp_t e;
        e.cs = cs; e.st = st; e.own = own; e.miss = miss; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " ready"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_xfer(input int m, input string tag);
        @(negedge clk);
        mach_done = 5'(1 << m);
        @(negedge clk);
        mach_done = '0;
        chk(cs_n == 4'hF && !owner_valid, tag, {27'd0, owner_valid, cs_n}, 32'h0000_000F);
    endtask

    task automatic refresh_end(input string tag);
        @(negedge clk);
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
        chk(cs_n == 4'hF && !refresh_active, tag, {27'd0, refresh_active, cs_n}, 32'h0000_000F);
    endtask

    // monitor: pop and compare on every start pulse or miss pulse
    always @(negedge clk) begin
        if (rst_n && (mach_start != 5'd0 || miss_err)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard unexpected event", {19'd0, cs_n, mach_start, miss_err, owner}, 32'd0);
            end else begin
                exp_t e;
                logic [31:0] act, exp;
                e = sb_q.pop_front();
                act = {19'd0, cs_n, mach_start, miss_err, (miss_err ? 3'd0 : owner)};
                exp = {19'd0, e.cs, e.st, e.miss, (e.miss ? 3'd0 : e.own)};
                chk(act == exp, e.tag, act, exp);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF && !owner_valid && !refresh_active, "R1 in reset",
            {27'd0, owner_valid, cs_n}, 32'h0000_000F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && req_ready && !refresh_active, "R1 after reset",
            {26'd0, refresh_active, req_ready, cs_n}, 32'h0000_001F);

        // R11: field select 0 base, 1 mask, 2 ctrl {ref_en, mach[2:0], valid}
        cfg(2'd0, 2'd0, 32'h0000_0000); cfg(2'd0, 2'd1, 32'hF000_0000); cfg(2'd0, 2'd2, 32'h01);
        cfg(2'd1, 2'd0, 32'h1000_0000); cfg(2'd1, 2'd1, 32'hF000_0000); cfg(2'd1, 2'd2, 32'h03);
        cfg(2'd2, 2'd0, 32'h2000_0000); cfg(2'd2, 2'd1, 32'hF000_0000); cfg(2'd2, 2'd2, 32'h15);
        cfg(2'd3, 2'd0, 32'h2000_0000); cfg(2'd3, 2'd1, 32'hFF00_0000); cfg(2'd3, 2'd2, 32'h17);

        // R2 / R6: general machine on bank 0
        do_req(32'h0ABC_0000, 4'b1110, 5'b00001, 3'd0, 1'b0, "R2 R6 bank0 general");
        chk(owner_valid && !req_ready, "R7 owned, not ready", {30'd0, owner_valid, req_ready}, 32'd2);
        // R7: another machine's done is ignored
        @(negedge clk); mach_done = 5'b00010;
        @(negedge clk); mach_done = '0;
        chk(cs_n == 4'b1110 && owner_valid, "R7 foreign done ignored", {27'd0, owner_valid, cs_n}, 32'h1E);
        finish_xfer(0, "R7 released by own done");

        do_req(32'h1234_5678, 4'b1101, 5'b00010, 3'd1, 1'b0, "R6 bank1 flash");
        finish_xfer(1, "R7 flash release");

        // R3: banks 2 and 3 both match, bank 2 wins
        do_req(32'h2000_0010, 4'b1011, 5'b00100, 3'd2, 1'b0, "R3 lowest bank wins");
        finish_xfer(2, "R3 release");

        // R9: refresh lights banks 2 and 3 together
        @(negedge clk); refresh_req = 1'b1;
        @(negedge clk); refresh_req = 1'b0;
        chk(refresh_active && cs_n == 4'b0011 && !req_ready, "R9 refresh set",
            {26'd0, refresh_active, req_ready, cs_n}, 32'h23);
        @(negedge clk);
        chk(refresh_active && cs_n == 4'b0011, "R9 refresh held", {27'd0, refresh_active, cs_n}, 32'h13);
        refresh_end("R9 refresh end");

        // R10: refresh deferred behind a transfer
        do_req(32'h0000_0040, 4'b1110, 5'b00001, 3'd0, 1'b0, "R10 transfer before refresh");
        @(negedge clk); refresh_req = 1'b1;
        @(negedge clk); refresh_req = 1'b0;
        chk(cs_n == 4'b1110 && !refresh_active && !req_ready, "R10 refresh pending",
            {26'd0, refresh_active, req_ready, cs_n}, 32'h0E);
        @(negedge clk); mach_done = 5'b00001;
        @(negedge clk); mach_done = '0;
        chk(refresh_active && cs_n == 4'b0011 && !req_ready, "R10 refresh follows done",
            {26'd0, refresh_active, req_ready, cs_n}, 32'h23);
        refresh_end("R10 refresh end");

        // R4: invalidate bank 2 (keep other ctrl bits)
        cfg(2'd2, 2'd2, 32'h14);
        do_req(32'h2000_1234, 4'b0111, 5'b01000, 3'd3, 1'b0, "R4 invalid bank skipped");
        finish_xfer(3, "R4 release");
        do_req(32'h2100_0000, 4'b1111, 5'b00000, 3'd0, 1'b1, "R4 invalid bank no match");

        // R5: address outside every window
        do_req(32'h5000_0000, 4'b1111, 5'b00000, 3'd0, 1'b1, "R5 miss");
        @(negedge clk);
        chk(!miss_err && cs_n == 4'hF, "R5 miss one cycle", {27'd0, miss_err, cs_n}, 32'h0F);

        // R9: refresh set now only bank 3
        @(negedge clk); refresh_req = 1'b1;
        @(negedge clk); refresh_req = 1'b0;
        chk(refresh_active && cs_n == 4'b0111, "R9 refresh after invalidate",
            {27'd0, refresh_active, cs_n}, 32'h17);
        refresh_end("R9 refresh end 2");

        // R11: machine code 5 never matches
        cfg(2'd1, 2'd2, 32'h0B);
        do_req(32'h1000_0000, 4'b1111, 5'b00000, 3'd0, 1'b1, "R11 bad machine code");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule